// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block takes an SDRAM device from power-on to its first usable state. Once reset is released it holds clock-enable and the data mask high and presents only no-operation commands for a stabilization interval. That interval is at least 200 microseconds and is converted to clock cycles from a clock-frequency parameter. The block then issues a precharge to every bank, a programmable number of auto-refresh commands and one mode-register write, with a fixed gap in cycles after each command. When the last gap has elapsed it raises a done flag.

The mode word is built at elaboration from parameters for CAS latency, burst type, burst length and write-burst behaviour. Reserved fields are always written as zero, and CAS latency codes other than those for 2 and 3 are never produced. A parameter chooses whether the mode write comes before or after the refresh commands. Everything is configured through parameters, so the only run-time inputs are the clock and a synchronous active-high reset. Read/write traffic and periodic refresh are left to the controller that takes over after done.

Top module: `sdram_powerup_seq`

## Requirements
- R1: During reset and for as long as the block runs, `sd_cke` and `sd_dqm` are 1. In reset the command pins {cs_n,ras_n,cas_n,we_n} read 4'b0111 (no-operation), `sd_addr` and `sd_ba` are 0 and `init_done` is 0.
- R2: The first command other than a no-operation is a precharge-all: command 4'b0010, `sd_addr` = 12'h400 (only bit 10 set) and `sd_ba` = 0. Counting the first clock edge with reset low as edge 0, it leaves the block on edge WAIT_US*CLK_MHZ-1. Only no-operations come before it.
- R3: Counted in clock edges, a command that follows another comes T_RP edges after a precharge, T_RC edges after an auto-refresh and T_MRD edges after a mode write. Only no-operations appear in between.
- R4: Exactly REFRESH_COUNT auto-refresh commands are issued, each as command 4'b0001 with `sd_addr` = 0 and `sd_ba` = 0. The count is at least 2.
- R5: Exactly one mode write is issued, as command 4'b0000, with `sd_ba` = 0 and this `sd_addr` layout: [2:0] burst length code (1→000, 2→001, 4→010, 8→011, 256→111), [3] burst type (1 = interleaved), [6:4] CAS latency code, [8:7] = 00, [9] = 1 for single-location writes, [11:10] = 00.
- R6: A CAS_LATENCY of 3 gives code 011. Any other value gives 010. No other code is ever written.
- R7: With a burst length of 256 (full page), bit 3 of the mode word is 0 even if an interleaved burst is requested.
- R8: With MODE_FIRST = 0 the order is precharge, the refreshes, then the mode write. With MODE_FIRST = 1 it is precharge, the mode write, then the refreshes.
- R9: `init_done` rises on the edge that lies one gap (T_MRD or T_RC, matching the last command) after the last command. It then stays 1 until reset, and no further command other than a no-operation is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sd_cke | output | 1 | SDRAM clock enable |
| sd_dqm | output | 1 | SDRAM data mask |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_addr | output | 12 | Address lines; carry the precharge-all flag and the mode word |
| sd_ba | output | 2 | Bank select |
| init_done | output | 1 | High once initialization has completed |

## Verification
The ordering variant and the full-page/interleave collision are fixed by parameters, not by any input, so no stimulus on a single instance can reach both orders. The bench therefore runs two instances side by side. One uses refresh-first order with three refreshes, CAS latency 3, interleaved bursts of 8 and single writes. The other uses mode-first order with a full-page burst and an interleave request that must be overridden. A clock-frequency parameter of 1 or 2 MHz brings the 200-microsecond wait down to a few hundred cycles, so each instance's edge-exact schedule can be predicted and compared end to end.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

    localparam int SD_ADDR_W     = 12;
    localparam int SD_BANK_W     = 2;
    localparam int FULL_PAGE_LEN = 256;

    // Command encoding as {cs_n, ras_n, cas_n, we_n}
    typedef enum logic [3:0] {
        CMD_MODE_SET  = 4'b0000,
        CMD_REFRESH   = 4'b0001,
        CMD_PRECHARGE = 4'b0010,
        CMD_NOP       = 4'b0111
    } sd_cmd_e;

    typedef enum logic [2:0] {
        PH_STABLE,
        PH_PRE_WAIT,
        PH_REF_WAIT,
        PH_MODE_WAIT,
        PH_READY
    } init_phase_e;

    // Mode word, most significant field first; bank bits ride on the bank lines
    typedef struct packed {
        logic [1:0] bank;
        logic [1:0] rfu;
        logic       wr_single;
        logic [1:0] test;
        logic [2:0] cas;
        logic       interleave;
        logic [2:0] blen;
    } mode_word_t;

    function automatic logic [2:0] blen_code(input int len);
        case (len)
            1:       return 3'b000;
            2:       return 3'b001;
            4:       return 3'b010;
            8:       return 3'b011;
            default: return 3'b111;
        endcase
    endfunction

    function automatic logic [2:0] cas_code(input int lat);
        return (lat == 3) ? 3'b011 : 3'b010;
    endfunction

    function automatic mode_word_t build_mode(input int lat, input int len,
                                              input bit interleave, input bit single_wr);
        mode_word_t m;
        m.bank       = '0;
        m.rfu        = '0;
        m.test       = '0;
        m.wr_single  = single_wr;
        m.cas        = cas_code(lat);
        m.blen       = blen_code(len);
        m.interleave = interleave && (len != FULL_PAGE_LEN) && (m.blen != 3'b111);
        return m;
    endfunction

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/init_wait_timer.sv
module init_wait_timer
    import sdram_init_pkg::*;
#(
    parameter int CW        = 16,
    parameter int RESET_VAL = 0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expired
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= CW'(RESET_VAL);
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign expired = (cnt == '0);

endmodule

// File: rtl/init_step_ctrl.sv
module init_step_ctrl
    import sdram_init_pkg::*;
#(
    parameter int CW         = 16,
    parameter int REFS       = 2,
    parameter bit MODE_FIRST = 1'b0,
    parameter int T_RP       = 3,
    parameter int T_RC       = 9,
    parameter int T_MRD      = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          expired,
    output sd_cmd_e       issue_cmd,
    output logic          load,
    output logic [CW-1:0] load_val,
    output logic          go_ready
);
    localparam int RW = $clog2(REFS + 1);
    localparam logic [CW-1:0] GAP_RP  = CW'(T_RP - 1);
    localparam logic [CW-1:0] GAP_RC  = CW'(T_RC - 1);
    localparam logic [CW-1:0] GAP_MRD = CW'(T_MRD - 1);
    localparam logic [RW-1:0] REFS_AFTER_FIRST = RW'(REFS - 1);

    init_phase_e   phase, phase_n;
    logic [RW-1:0] refs_left, refs_left_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= PH_STABLE;
            refs_left <= '0;
        end else begin
            phase     <= phase_n;
            refs_left <= refs_left_n;
        end
    end

    always_comb begin
        issue_cmd   = CMD_NOP;
        load        = 1'b0;
        load_val    = '0;
        go_ready    = 1'b0;
        phase_n     = phase;
        refs_left_n = refs_left;
        if (expired) begin
            case (phase)
                PH_STABLE: begin
                    issue_cmd = CMD_PRECHARGE;
                    load      = 1'b1;
                    load_val  = GAP_RP;
                    phase_n   = PH_PRE_WAIT;
                end
                PH_PRE_WAIT: begin
                    load = 1'b1;
                    if (MODE_FIRST) begin
                        issue_cmd = CMD_MODE_SET;
                        load_val  = GAP_MRD;
                        phase_n   = PH_MODE_WAIT;
                    end else begin
                        issue_cmd   = CMD_REFRESH;
                        load_val    = GAP_RC;
                        refs_left_n = REFS_AFTER_FIRST;
                        phase_n     = PH_REF_WAIT;
                    end
                end
                PH_REF_WAIT: begin
                    if (refs_left != '0) begin
                        issue_cmd   = CMD_REFRESH;
                        load        = 1'b1;
                        load_val    = GAP_RC;
                        refs_left_n = refs_left - 1'b1;
                    end else if (!MODE_FIRST) begin
                        issue_cmd = CMD_MODE_SET;
                        load      = 1'b1;
                        load_val  = GAP_MRD;
                        phase_n   = PH_MODE_WAIT;
                    end else begin
                        go_ready = 1'b1;
                        phase_n  = PH_READY;
                    end
                end
                PH_MODE_WAIT: begin
                    if (MODE_FIRST) begin
                        issue_cmd   = CMD_REFRESH;
                        load        = 1'b1;
                        load_val    = GAP_RC;
                        refs_left_n = REFS_AFTER_FIRST;
                        phase_n     = PH_REF_WAIT;
                    end else begin
                        go_ready = 1'b1;
                        phase_n  = PH_READY;
                    end
                end
                default: begin
                    phase_n = PH_READY;
                end
            endcase
        end
    end

endmodule

// File: rtl/init_pin_driver.sv
module init_pin_driver
    import sdram_init_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  sd_cmd_e              issue_cmd,
    input  mode_word_t           mode,
    input  logic                 go_ready,
    output logic                 cke,
    output logic                 dqm,
    output sd_cmd_e              cmd,
    output logic [SD_ADDR_W-1:0] addr,
    output logic [SD_BANK_W-1:0] bank,
    output logic                 done
);
    logic [SD_ADDR_W-1:0] addr_n;
    logic [SD_BANK_W-1:0] bank_n;

    always_comb begin
        addr_n = '0;
        bank_n = '0;
        case (issue_cmd)
            CMD_PRECHARGE: addr_n[10] = 1'b1;
            CMD_MODE_SET: begin
                addr_n = mode[SD_ADDR_W-1:0];
                bank_n = mode.bank;
            end
            default: addr_n = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cke  <= 1'b1;
            dqm  <= 1'b1;
            cmd  <= CMD_NOP;
            addr <= '0;
            bank <= '0;
            done <= 1'b0;
        end else begin
            cke  <= 1'b1;
            dqm  <= 1'b1;
            cmd  <= issue_cmd;
            addr <= addr_n;
            bank <= bank_n;
            done <= done | go_ready;
        end
    end

endmodule

// File: rtl/sdram_powerup_seq.sv
module sdram_powerup_seq
    import sdram_init_pkg::*;
#(
    parameter int CLK_MHZ          = 100,
    parameter int WAIT_US          = 200,
    parameter int REFRESH_COUNT    = 2,
    parameter int CAS_LATENCY      = 2,
    parameter int BURST_LEN        = 4,
    parameter bit BURST_INTERLEAVE = 1'b0,
    parameter bit WRITE_SINGLE     = 1'b0,
    parameter bit MODE_FIRST       = 1'b0,
    parameter int T_RP             = 3,
    parameter int T_RC             = 9,
    parameter int T_MRD            = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    output logic                 sd_cke,
    output logic                 sd_dqm,
    output logic                 sd_cs_n,
    output logic                 sd_ras_n,
    output logic                 sd_cas_n,
    output logic                 sd_we_n,
    output logic [SD_ADDR_W-1:0] sd_addr,
    output logic [SD_BANK_W-1:0] sd_ba,
    output logic                 init_done
);
    localparam int WAIT_CYC = max_of(WAIT_US * CLK_MHZ, 1);
    localparam int REFS     = max_of(REFRESH_COUNT, 2);
    localparam int MAX_GAP  = max_of(max_of(WAIT_CYC, T_RP), max_of(T_RC, T_MRD));
    localparam int CW       = $clog2(MAX_GAP + 1);
    localparam mode_word_t MODE_WORD =
        build_mode(CAS_LATENCY, BURST_LEN, BURST_INTERLEAVE, WRITE_SINGLE);

    logic          expired;
    logic          load;
    logic [CW-1:0] load_val;
    logic          go_ready;
    sd_cmd_e       issue_cmd;
    sd_cmd_e       pin_cmd;

    init_wait_timer #(
        .CW        (CW),
        .RESET_VAL (WAIT_CYC - 1)
    ) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .load_val (load_val),
        .expired  (expired)
    );

    init_step_ctrl #(
        .CW         (CW),
        .REFS       (REFS),
        .MODE_FIRST (MODE_FIRST),
        .T_RP       (T_RP),
        .T_RC       (T_RC),
        .T_MRD      (T_MRD)
    ) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .expired   (expired),
        .issue_cmd (issue_cmd),
        .load      (load),
        .load_val  (load_val),
        .go_ready  (go_ready)
    );

    init_pin_driver u_pins (
        .clk       (clk),
        .rst       (rst),
        .issue_cmd (issue_cmd),
        .mode      (MODE_WORD),
        .go_ready  (go_ready),
        .cke       (sd_cke),
        .dqm       (sd_dqm),
        .cmd       (pin_cmd),
        .addr      (sd_addr),
        .bank      (sd_ba),
        .done      (init_done)
    );

    assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = pin_cmd;

endmodule

// File: rtl/sdram_powerup_seq_chk.sv
module sdram_powerup_seq_chk #(
    parameter int CLK_MHZ = 100,
    parameter int WAIT_US = 200
) (
    input logic        clk,
    input logic        rst,
    input logic        sd_cke,
    input logic        sd_dqm,
    input logic        sd_cs_n,
    input logic        sd_ras_n,
    input logic        sd_cas_n,
    input logic        sd_we_n,
    input logic [11:0] sd_addr,
    input logic [1:0]  sd_ba,
    input logic        init_done
);
    localparam int WAIT_CYC = (WAIT_US * CLK_MHZ > 1) ? WAIT_US * CLK_MHZ : 1;

    logic [3:0]  cmd;
    logic [31:0] cyc;
    logic        seen_cmd;

    assign cmd = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};

    always_ff @(posedge clk) begin
        if (rst) begin
            cyc      <= '0;
            seen_cmd <= 1'b0;
        end else begin
            if (cyc != '1) cyc <= cyc + 1'b1;
            if (cmd != 4'b0111) seen_cmd <= 1'b1;
        end
    end

    assert_pins_held_R1: assert property (@(posedge clk) disable iff (rst)
        sd_cke && sd_dqm);

    assert_first_is_precharge_R2: assert property (@(posedge clk) disable iff (rst)
        (cmd != 4'b0111 && !seen_cmd) |-> (cmd == 4'b0010 && cyc == 32'(WAIT_CYC)));

    assert_precharge_all_R2: assert property (@(posedge clk) disable iff (rst)
        (cmd == 4'b0010) |-> (sd_addr == 12'h400 && sd_ba == 2'b00));

    assert_mode_reserved_zero_R5: assert property (@(posedge clk) disable iff (rst)
        (cmd == 4'b0000) |-> (sd_addr[11:10] == 2'b00 && sd_addr[8:7] == 2'b00 && sd_ba == 2'b00));

    assert_cas_code_legal_R6: assert property (@(posedge clk) disable iff (rst)
        (cmd == 4'b0000) |-> (sd_addr[6:4] == 3'b010 || sd_addr[6:4] == 3'b011));

    assert_full_page_sequential_R7: assert property (@(posedge clk) disable iff (rst)
        (cmd == 4'b0000 && sd_addr[2:0] == 3'b111) |-> !sd_addr[3]);

    assert_done_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        init_done |=> init_done);

    assert_quiet_after_done_R9: assert property (@(posedge clk) disable iff (rst)
        init_done |-> (cmd == 4'b0111));

endmodule

bind sdram_powerup_seq sdram_powerup_seq_chk #(
    .CLK_MHZ (CLK_MHZ),
    .WAIT_US (WAIT_US)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .sd_cke    (sd_cke),
    .sd_dqm    (sd_dqm),
    .sd_cs_n   (sd_cs_n),
    .sd_ras_n  (sd_ras_n),
    .sd_cas_n  (sd_cas_n),
    .sd_we_n   (sd_we_n),
    .sd_addr   (sd_addr),
    .sd_ba     (sd_ba),
    .init_done (init_done)
);

// File: tb/tb_sdram_powerup_seq.sv
module tb_sdram_powerup_seq;
    localparam int CLK_PERIOD = 10;
    localparam int END_EDGE   = 430;

    // instance 0: refresh first; instance 1: mode write first, full page
    localparam int A_MHZ = 1, A_REFS = 3, A_CL = 3, A_BL = 8,   A_RP = 3, A_RC = 7, A_MRD = 2;
    localparam bit A_IL = 1'b1, A_WS = 1'b1, A_MF = 1'b0;
    localparam int B_MHZ = 2, B_REFS = 2, B_CL = 2, B_BL = 256, B_RP = 2, B_RC = 5, B_MRD = 3;
    localparam bit B_IL = 1'b1, B_WS = 1'b0, B_MF = 1'b1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #(CLK_PERIOD / 2) clk = ~clk;

    logic [1:0]  cke, dqm, csn, rasn, casn, wen, done;
    logic [11:0] addr [2];
    logic [1:0]  ba   [2];

    sdram_powerup_seq #(
        .CLK_MHZ(A_MHZ), .REFRESH_COUNT(A_REFS), .CAS_LATENCY(A_CL), .BURST_LEN(A_BL),
        .BURST_INTERLEAVE(A_IL), .WRITE_SINGLE(A_WS), .MODE_FIRST(A_MF),
        .T_RP(A_RP), .T_RC(A_RC), .T_MRD(A_MRD)
    ) dut (
        .clk(clk), .rst(rst), .sd_cke(cke[0]), .sd_dqm(dqm[0]), .sd_cs_n(csn[0]),
        .sd_ras_n(rasn[0]), .sd_cas_n(casn[0]), .sd_we_n(wen[0]),
        .sd_addr(addr[0]), .sd_ba(ba[0]), .init_done(done[0])
    );

    sdram_powerup_seq #(
        .CLK_MHZ(B_MHZ), .REFRESH_COUNT(B_REFS), .CAS_LATENCY(B_CL), .BURST_LEN(B_BL),
        .BURST_INTERLEAVE(B_IL), .WRITE_SINGLE(B_WS), .MODE_FIRST(B_MF),
        .T_RP(B_RP), .T_RC(B_RC), .T_MRD(B_MRD)
    ) dut_alt (
        .clk(clk), .rst(rst), .sd_cke(cke[1]), .sd_dqm(dqm[1]), .sd_cs_n(csn[1]),
        .sd_ras_n(rasn[1]), .sd_cas_n(casn[1]), .sd_we_n(wen[1]),
        .sd_addr(addr[1]), .sd_ba(ba[1]), .init_done(done[1])
    );

    typedef struct {
        int          cyc;
        logic [3:0]  cmd;
        logic [11:0] addr;
        string       tag;
    } exp_t;

    exp_t exp_q [2][$];
    int   done_at [2];
    int   k = -1;
    int   n_checks = 0;
    int   n_fail = 0;
    bit   finished = 1'b0;

    always @(posedge clk) begin
        if (rst) k <= -1;
        else     k <= k + 1;
    end

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h (edge %0d)", tag, what, act, expv, k);
        end
    endtask

    task automatic push_exp(input int idx, input int cyc, input logic [3:0] cmd,
                            input logic [11:0] a, input string tag);
        exp_t e;
        e.cyc = cyc; e.cmd = cmd; e.addr = a; e.tag = tag;
        exp_q[idx].push_back(e);
    endtask

    function automatic logic [11:0] want_mode(input int cl, input int bl,
                                              input bit il, input bit ws);
        logic [2:0] blc;
        logic [11:0] w;
        case (bl)
            1: blc = 3'b000;
            2: blc = 3'b001;
            4: blc = 3'b010;
            8: blc = 3'b011;
            default: blc = 3'b111;
        endcase
        w = '0;
        w[2:0] = blc;
        w[3]   = il && (bl != 256);
        w[6:4] = (cl == 3) ? 3'b011 : 3'b010;
        w[9]   = ws;
        return w;
    endfunction

    task automatic plan_seq(input int idx, input int mhz, input int refs, input bit mf,
                            input int rp, input int rc, input int mrd, input logic [11:0] mw);
        int t;
        t = 200 * mhz - 1;
        push_exp(idx, t, 4'b0010, 12'h400, "R2");
        t += rp;
        if (!mf) begin
            for (int i = 0; i < refs; i++) begin
                push_exp(idx, t, 4'b0001, 12'h000, "R3 R4 R8");
                t += rc;
            end
            push_exp(idx, t, 4'b0000, mw, "R5 R6 R8");
            t += mrd;
        end else begin
            push_exp(idx, t, 4'b0000, mw, "R5 R7 R8");
            t += mrd;
            for (int i = 0; i < refs; i++) begin
                push_exp(idx, t, 4'b0001, 12'h000, "R3 R4 R8");
                t += rc;
            end
        end
        done_at[idx] = t;
    endtask

    // monitor: pops the expected command stream as the design produces it
    task automatic monitor(input int idx);
        logic [3:0] c;
        exp_t e;
        c = {csn[idx], rasn[idx], casn[idx], wen[idx]};
        if (c != 4'b0111) begin
            if (exp_q[idx].size() == 0) begin
                check(1'b0, "R9", "command after sequence", int'(c), 7);
            end else begin
                e = exp_q[idx].pop_front();
                check(e.cyc == k, e.tag, "issue edge", k, e.cyc);
                check(c == e.cmd, e.tag, "command code", int'(c), int'(e.cmd));
                check(addr[idx] == e.addr, e.tag, "address", int'(addr[idx]), int'(e.addr));
                check(ba[idx] == 2'b00, "R5", "bank lines", int'(ba[idx]), 0);
                check(cke[idx] && dqm[idx], "R1", "cke/dqm", int'({cke[idx], dqm[idx]}), 3);
            end
        end else if (exp_q[idx].size() != 0 && exp_q[idx][0].cyc == k) begin
            e = exp_q[idx].pop_front();
            check(1'b0, e.tag, "missing command", 7, int'(e.cmd));
        end
        if (k == done_at[idx] - 1) check(done[idx] == 1'b0, "R9", "done early", int'(done[idx]), 0);
        if (k == done_at[idx])     check(done[idx] == 1'b1, "R9", "done rise", int'(done[idx]), 1);
    endtask

    always @(negedge clk) begin
        if (!rst && !finished) begin
            monitor(0);
            monitor(1);
        end
    end

    initial begin
        plan_seq(0, A_MHZ, A_REFS, A_MF, A_RP, A_RC, A_MRD, want_mode(A_CL, A_BL, A_IL, A_WS));
        plan_seq(1, B_MHZ, B_REFS, B_MF, B_RP, B_RC, B_MRD, want_mode(B_CL, B_BL, B_IL, B_WS));
        repeat (4) @(posedge clk);
        @(negedge clk);
        for (int i = 0; i < 2; i++) begin
            check(cke[i] && dqm[i], "R1", "reset cke/dqm", int'({cke[i], dqm[i]}), 3);
            check({csn[i], rasn[i], casn[i], wen[i]} == 4'b0111, "R1", "reset command",
                  int'({csn[i], rasn[i], casn[i], wen[i]}), 7);
            check(addr[i] == 12'h000 && ba[i] == 2'b00, "R1", "reset address",
                  int'({ba[i], addr[i]}), 0);
            check(done[i] == 1'b0, "R1", "reset done", int'(done[i]), 0);
        end
        rst = 1'b0;
        while (k < END_EDGE) @(negedge clk);
        for (int i = 0; i < 2; i++) begin
            check(exp_q[i].size() == 0, "R8", "commands left unissued", exp_q[i].size(), 0);
            check(done[i] == 1'b1, "R9", "done held", int'(done[i]), 1);
            check(cke[i] && dqm[i], "R1", "final cke/dqm", int'({cke[i], dqm[i]}), 3);
        end
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected finish by edge %0d", END_EDGE);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule